// File: doc/BRIEF.md
# Far-End Fault Generator and Detector

This block adds link-failure signalling to a serial fiber link that has no auto-negotiation. It handles one line bit per clock cycle in which `bit_en` is high. When the local signal-detect input reports that nothing is being received, the block stops forwarding transmit data and sends a fault cycle instead: a long run of ones closed by a single zero. It sends at least three of these cycles and keeps sending them for as long as the signal is missing.

At the same time the block watches the received bit stream for the same cycle shape. Three back-to-back cycles with the correct run length count as a fault report from the far end. A report forces the gated link status low, whatever the link monitor says. While that status is low, the transmit path carries idle, which is a run of ones at this level. The forced state clears once more than one cycle length of bit times passes without another valid cycle.

Line coding, scrambling and the analog detection of signal are handled elsewhere.

Top module: `remote_fault_link`

## Requirements
- R1: While the generator is sending, each fault cycle on `tx_out` is exactly 84 one bits followed by one zero bit, and consecutive cycles follow with no gap.
- R2: The generator starts at a `bit_en` edge that samples `sig_det` low while it is not sending. The first pattern bit appears in the bit time that follows that edge. Until that edge, `tx_out` still follows the normal path.
- R3: Once started, at least three complete fault cycles (255 bits) are sent, even if `sig_det` returns high straight away.
- R4: While `sig_det` stays low, cycles keep repeating. When it returns high after the minimum, the generator finishes the cycle in progress, including its zero, and only then gives the transmit path back.
- R5: When the generator is not sending and `link_up` is high, `tx_out` equals `tx_in`.
- R6: When the generator is not sending and `link_up` is low, `tx_out` is 1 (idle), whatever `tx_in` is.
- R7: `fault_flag` goes high at the `bit_en` edge that samples the zero closing the third consecutive valid received cycle. A valid cycle is exactly 84 ones followed by a zero. Further valid cycles keep the flag high.
- R8: A received zero that follows a run of fewer than 84 ones, or more than 84 ones, clears the count of valid cycles, so three new valid cycles are needed.
- R9: `link_up` is high only when `link_ok` is high and `fault_flag` is low.
- R10: With `fault_flag` high, 85 bit times after the last valid cycle completes leave it set. The 86th such bit time clears it.
- R11: Cycles with `bit_en` low change neither the generator position nor any detector state. In particular, `fault_flag` holds its value.
- R12: After reset the generator is not sending, `fault_flag` is low, and with `link_ok` and `sig_det` high, `tx_out` follows `tx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Marks a cycle that carries one line bit |
| sig_det | input | 1 | Local signal detect; low means no signal is received |
| link_ok | input | 1 | Link status from the link monitor |
| tx_in | input | 1 | Transmit bit from the data path |
| rx_bit | input | 1 | Received line bit |
| tx_out | output | 1 | Transmit bit toward the line |
| fault_flag | output | 1 | Far-end fault currently recognised |
| link_up | output | 1 | Link status gated by the fault detector |

## Verification
An error in the generator's position counter shows up on `tx_out` as a zero that arrives early or late. That is visible within one 85-bit cycle of the start. An error in the minimum-cycle count or in the stop condition moves the bit time at which `tx_in` reappears, so it shows at bit 255 or at the boundary of the cycle in progress. A detector whose run counter or cycle counter is off raises `fault_flag` one cycle too early or too late, or fails to clear it after a bad run length. This is visible at the closing zero of each received cycle. A wrong hold timer moves the fall of `fault_flag`, and so `link_up`, by at least one bit time around the 86th bit after the last valid cycle.

// File: rtl/remote_fault_pkg.sv
package remote_fault_pkg;

    // Default cycle shape: run of ones, then one zero
    localparam int unsigned DEF_ONES_LEN   = 84;
    // Minimum number of back-to-back cycles, sent and required on receive
    localparam int unsigned DEF_MIN_CYCLES = 3;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_SEND = 1'b1
    } gen_mode_e;

endpackage

// File: rtl/rf_fault_gen.sv
module rf_fault_gen
    import remote_fault_pkg::*;
#(
    parameter int unsigned ONES_LEN   = DEF_ONES_LEN,
    parameter int unsigned MIN_CYCLES = DEF_MIN_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic sig_det,
    output logic gen_active,
    output logic gen_bit
);

    localparam int unsigned POS_W = $clog2(ONES_LEN + 1);
    localparam int unsigned CYC_W = $clog2(MIN_CYCLES + 1);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(ONES_LEN);
    localparam logic [CYC_W-1:0] CYC_MAX   = CYC_W'(MIN_CYCLES);
    localparam logic [CYC_W-1:0] CYC_ENOUGH = CYC_W'(MIN_CYCLES - 1);

    typedef struct packed {
        gen_mode_e        mode;
        logic [POS_W-1:0] pos;
        logic [CYC_W-1:0] cycles;
    } gen_state_t;

    gen_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            unique case (st_q.mode)
                GEN_IDLE: begin
                    if (!sig_det) begin
                        st_d.mode   = GEN_SEND;
                        st_d.pos    = '0;
                        st_d.cycles = '0;
                    end
                end
                GEN_SEND: begin
                    if (st_q.pos == LAST_POS) begin
                        st_d.pos = '0;
                        if (st_q.cycles < CYC_MAX) begin
                            st_d.cycles = st_q.cycles + 1'b1;
                        end
                        if (sig_det && (st_q.cycles >= CYC_ENOUGH)) begin
                            st_d.mode = GEN_IDLE;
                        end
                    end else begin
                        st_d.pos = st_q.pos + 1'b1;
                    end
                end
                default: st_d.mode = GEN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: GEN_IDLE, pos: '0, cycles: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gen_active = (st_q.mode == GEN_SEND);
    assign gen_bit    = !(gen_active && (st_q.pos == LAST_POS));

endmodule

// File: rtl/rf_fault_det.sv
module rf_fault_det
    import remote_fault_pkg::*;
#(
    parameter int unsigned ONES_LEN   = DEF_ONES_LEN,
    parameter int unsigned MIN_CYCLES = DEF_MIN_CYCLES,
    parameter int unsigned HOLD_BITS  = DEF_ONES_LEN + 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic fault_flag
);

    localparam int unsigned RUN_W   = $clog2(ONES_LEN + 2);
    localparam int unsigned GOOD_W  = $clog2(MIN_CYCLES + 1);
    localparam int unsigned QUIET_W = $clog2(HOLD_BITS + 1);
    localparam logic [RUN_W-1:0]   RUN_EXACT = RUN_W'(ONES_LEN);
    localparam logic [RUN_W-1:0]   RUN_OVER  = RUN_W'(ONES_LEN + 1);
    localparam logic [GOOD_W-1:0]  GOOD_MAX  = GOOD_W'(MIN_CYCLES);
    localparam logic [GOOD_W-1:0]  GOOD_ARM  = GOOD_W'(MIN_CYCLES - 1);
    localparam logic [QUIET_W-1:0] QUIET_END = QUIET_W'(HOLD_BITS - 1);

    typedef struct packed {
        logic [RUN_W-1:0]   run;
        logic [GOOD_W-1:0]  good;
        logic [QUIET_W-1:0] quiet;
        logic               fault;
    } det_state_t;

    det_state_t st_q, st_d;
    logic       cycle_done;

    always_comb begin
        st_d       = st_q;
        cycle_done = bit_en && !rx_bit && (st_q.run == RUN_EXACT);
        if (bit_en) begin
            if (rx_bit) begin
                if (st_q.run != RUN_OVER) begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
                if (cycle_done) begin
                    if (st_q.good < GOOD_MAX) begin
                        st_d.good = st_q.good + 1'b1;
                    end
                end else begin
                    st_d.good = '0;
                end
            end

            if (cycle_done) begin
                st_d.quiet = '0;
                if (st_q.good >= GOOD_ARM) begin
                    st_d.fault = 1'b1;
                end
            end else if (st_q.fault) begin
                if (st_q.quiet == QUIET_END) begin
                    st_d.fault = 1'b0;
                    st_d.quiet = '0;
                    st_d.good  = '0;
                end else begin
                    st_d.quiet = st_q.quiet + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_flag = st_q.fault;

endmodule

// File: rtl/rf_tx_select.sv
module rf_tx_select (
    input  logic tx_in,
    input  logic gen_active,
    input  logic gen_bit,
    input  logic link_up,
    output logic tx_out
);

    always_comb begin
        if (gen_active) begin
            tx_out = gen_bit;
        end else if (!link_up) begin
            tx_out = 1'b1;
        end else begin
            tx_out = tx_in;
        end
    end

endmodule

// File: rtl/remote_fault_link.sv
module remote_fault_link
    import remote_fault_pkg::*;
#(
    parameter int unsigned ONES_LEN   = DEF_ONES_LEN,
    parameter int unsigned MIN_CYCLES = DEF_MIN_CYCLES,
    parameter int unsigned HOLD_BITS  = DEF_ONES_LEN + 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic sig_det,
    input  logic link_ok,
    input  logic tx_in,
    input  logic rx_bit,
    output logic tx_out,
    output logic fault_flag,
    output logic link_up
);

    logic gen_active;
    logic gen_bit;

    rf_fault_gen #(
        .ONES_LEN  (ONES_LEN),
        .MIN_CYCLES(MIN_CYCLES)
    ) i_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .sig_det   (sig_det),
        .gen_active(gen_active),
        .gen_bit   (gen_bit)
    );

    rf_fault_det #(
        .ONES_LEN  (ONES_LEN),
        .MIN_CYCLES(MIN_CYCLES),
        .HOLD_BITS (HOLD_BITS)
    ) i_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .fault_flag(fault_flag)
    );

    assign link_up = link_ok && !fault_flag;

    rf_tx_select i_sel (
        .tx_in     (tx_in),
        .gen_active(gen_active),
        .gen_bit   (gen_bit),
        .link_up   (link_up),
        .tx_out    (tx_out)
    );

endmodule

// File: rtl/rf_checker.sv
module rf_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic sig_det,
    input logic rx_bit,
    input logic fault_flag,
    input logic gen_active,
    input logic gen_bit
);

    // R7
    fault_rise_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> ($past(bit_en) && !$past(rx_bit)));

    // R11
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(fault_flag));

    // R2
    gen_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !sig_det && !gen_active) |=> gen_active);

    // R4
    gen_stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gen_active) |-> ($past(bit_en) && $past(sig_det) && !$past(gen_bit)));

    // R1
    gen_single_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && gen_active && !gen_bit) |=> gen_bit);

endmodule

bind remote_fault_link rf_checker i_rf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .sig_det   (sig_det),
    .rx_bit    (rx_bit),
    .fault_flag(fault_flag),
    .gen_active(gen_active),
    .gen_bit   (gen_bit)
);

// File: tb/test_remote_fault_link.sv
module test_remote_fault_link;

    localparam int CLK_PERIOD = 10;
    localparam int ONES       = 84;

    logic clk = 1'b0;
    logic rst_n;
    logic bit_en, sig_det, link_ok, tx_in, rx_bit;
    logic tx_out, fault_flag, link_up;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    remote_fault_link i_remote_fault_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .sig_det   (sig_det),
        .link_ok   (link_ok),
        .tx_in     (tx_in),
        .rx_bit    (rx_bit),
        .tx_out    (tx_out),
        .fault_flag(fault_flag),
        .link_up   (link_up)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rx_send(input logic b);
        rx_bit = b;
        bit_en = 1'b1;
        tick();
    endtask

    task automatic rx_cycle(input int ones);
        for (int i = 0; i < ones; i++) rx_send(1'b1);
        rx_send(1'b0);
    endtask

    task automatic test_reset();
        check("R12 fault_flag after reset", fault_flag, 1'b0);
        check("R9 link_up after reset", link_up, 1'b1);
        tx_in = 1'b0; #1;
        check("R12 R5 tx_out follows tx_in=0", tx_out, 1'b0);
        tx_in = 1'b1; #1;
        check("R5 tx_out follows tx_in=1", tx_out, 1'b1);
        tx_in = 1'b0;
    endtask

    task automatic test_gen_minimum();
        int errs;
        bit gap_ok;
        tx_in = 1'b0; bit_en = 1'b1;
        sig_det = 1'b0; #1;
        check("R2 no pattern before start edge", tx_out, 1'b0);
        tick();
        sig_det = 1'b1;
        errs = 0;
        gap_ok = 1'b1;
        for (int i = 0; i < 3*(ONES+1); i++) begin
            if (tx_out !== ((i % (ONES+1)) == ONES ? 1'b0 : 1'b1)) errs++;
            if (i == 40) begin
                bit_en = 1'b0;
                for (int k = 0; k < 5; k++) begin
                    tick();
                    if (tx_out !== 1'b1) gap_ok = 1'b0;
                end
                bit_en = 1'b1;
            end
            tick();
        end
        check("R1 R3 three full cycles sent", errs == 0, 1'b1);
        check("R11 generator holds during bit_en low", gap_ok, 1'b1);
        check("R4 tx_in returns after minimum", tx_out, 1'b0);
    endtask

    task automatic test_gen_extend();
        int errs;
        tx_in = 1'b0; bit_en = 1'b1;
        sig_det = 1'b0;
        tick();
        errs = 0;
        for (int i = 0; i < 4*(ONES+1); i++) begin
            if (tx_out !== ((i % (ONES+1)) == ONES ? 1'b0 : 1'b1)) errs++;
            if (i == 300) sig_det = 1'b1;
            tick();
        end
        check("R4 fourth cycle completed untruncated", errs == 0, 1'b1);
        check("R4 handback at cycle boundary", tx_out, 1'b0);
    endtask

    task automatic test_idle();
        link_ok = 1'b0; tx_in = 1'b0; #1;
        check("R9 link_up low with link_ok low", link_up, 1'b0);
        check("R6 idle ones when link low", tx_out, 1'b1);
        link_ok = 1'b1; #1;
        check("R5 data path restored", tx_out, 1'b0);
    endtask

    task automatic test_detect();
        tx_in = 1'b0;
        rx_send(1'b0);
        rx_cycle(ONES);
        rx_cycle(ONES);
        check("R7 no fault after two cycles", fault_flag, 1'b0);
        for (int i = 0; i < ONES; i++) rx_send(1'b1);
        check("R7 no fault before third zero", fault_flag, 1'b0);
        rx_send(1'b0);
        check("R7 fault after third cycle", fault_flag, 1'b1);
        check("R9 link_up forced low", link_up, 1'b0);
        check("R6 idle while fault", tx_out, 1'b1);
        bit_en = 1'b0;
        rx_bit = 1'b0;
        for (int i = 0; i < 200; i++) tick();
        check("R11 fault held without bit times", fault_flag, 1'b1);
        rx_cycle(ONES);
        check("R7 fault kept by further cycle", fault_flag, 1'b1);
        for (int i = 0; i < 85; i++) rx_send(1'b1);
        check("R10 fault held after 85 bits", fault_flag, 1'b1);
        rx_send(1'b1);
        check("R10 fault cleared at 86th bit", fault_flag, 1'b0);
        check("R9 link_up restored", link_up, 1'b1);
    endtask

    task automatic test_bad_runs();
        rx_send(1'b0);
        rx_cycle(ONES); rx_cycle(ONES); rx_cycle(ONES-1);
        rx_cycle(ONES); rx_cycle(ONES);
        check("R8 short run resets count", fault_flag, 1'b0);
        rx_cycle(ONES);
        check("R8 three new cycles detected", fault_flag, 1'b1);
        for (int i = 0; i < 90; i++) rx_send(1'b1);
        check("R10 released by ones", fault_flag, 1'b0);
        rx_send(1'b0);
        rx_cycle(ONES); rx_cycle(ONES); rx_cycle(ONES+1);
        rx_cycle(ONES); rx_cycle(ONES);
        check("R8 long run resets count", fault_flag, 1'b0);
        rx_cycle(ONES);
        check("R8 detection after long run", fault_flag, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; bit_en = 1'b0; sig_det = 1'b1; link_ok = 1'b1;
        tx_in = 1'b0; rx_bit = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        test_reset();
        test_gen_minimum();
        test_gen_extend();
        test_idle();
        test_detect();
        test_bad_runs();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule